// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block is the control side of a byte-wide NOR-style flash device. A small internal RAM stands in for the cell array. The block watches the active-low chip-enable, output-enable, write-enable and reset/power-down pins, which are sampled on a system clock. A write cycle is taken when write-enable returns high while chip-enable is low. The written byte goes to a command interpreter. That interpreter selects what a read returns: array data, identification bytes or the status byte. It also runs the two-cycle sequences that alter the array.

Alteration is modelled with fixed cycle counts. A byte write clears bits after a set delay. A block erase sets one byte of the block to FFH per step. Per-block lock flags can refuse alteration, and so can a low programming-voltage flag. A busy/ready output tracks the operation. An erase can be paused so that other blocks can be read or written, and a byte write can be paused so that other locations can be read. Pulling the reset/power-down pin low puts the device to sleep and cuts off any operation in progress. On waking, the device returns to array reads with a clean status byte.

Top module: `flash_ctl_front`

## Requirements
- R1: After reset, and after leaving power-down, reads return array data without any command being written, and the status byte reads 80H.
- R2: Command FFH selects array reads, 90H selects identification reads and 70H selects status reads. In identification mode, address bits [1:0] = 0 return MFR_ID, 1 returns DEV_ID and 2 returns the addressed block's lock flag in bit 0.
- R3: The data bus is driven (dq_oe = 1) only while ce_n = 0, oe_n = 0, we_n = 1 and the device is awake. At all other times dq_oe = 0.
- R4: Command 40H followed by an address/data cycle stores old AND data at that address after WRITE_CYC cycles. ry_by_n is low from the cycle after the data cycle until completion, and reads then return the status byte.
- R5: Command 20H followed by D0H erases the addressed block to FFH, one byte per ERASE_DIV cycles, in ascending order. Any other confirm byte sets status bit 5 and alters nothing.
- R6: Taking ce_n high during an operation does not stop it.
- R7: After rp_n goes low, the device stays asleep (outputs disabled) for at least RP_MIN cycles and until rp_n is high. It then spends WAKE_CYC further cycles waking.
- R8: rp_n low during an erase, write or lock operation aborts it. ry_by_n stays low until waking ends, and the bytes already erased stay erased.
- R9: With vpp_low = 1 at the confirm cycle, no alteration starts and status bit 3 is set.
- R10: 60H then 01H sets the addressed block's lock flag, and 60H then D0H clears all lock flags. An erase or write aimed at a locked block is refused with status bit 1.
- R11: B0H during an erase pauses it with status bits 7 and 6 set. Reads work, and a byte write to another block is accepted. D0H resumes the erase.
- R12: B0H during a byte write (outside an erase pause) pauses it with status bits 7 and 2 set, before the byte is altered. D0H resumes it.
- R13: Status error bits 5, 3 and 1 are cleared when the next 20H, 40H or 60H command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| rp_n | input | 1 | Reset / deep power-down, active low |
| vpp_low | input | 1 | Programming voltage below lockout level |
| addr | input | AW | Byte address |
| dq_in | input | 8 | Data bus, inbound |
| dq_out | output | 8 | Data bus, outbound |
| dq_oe | output | 1 | Drive enable for dq_out; 0 means high impedance |
| ry_by_n | output | 1 | Low while busy or while an aborted operation is being reset |

## Verification
The hardest state to reach is the abort in the middle of an erase. The pin has to fall after some bytes of the block are erased and before the others are, and only the per-byte timing of the erase tells which bytes those are. The stimulus first puts known values at both ends of one block. It then starts an erase there and counts a fixed number of cycles before pulling rp_n low, so that the first byte is erased and the last is not. It then checks the busy output through the power-down and wake period, and reads both ends back in array mode without writing any command. Nested pauses, where a byte write runs inside a paused erase, are reached the same way: the bench counts cycles between the confirm cycle and the pause command.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_WRITE      = 8'h40;
    localparam logic [7:0] CMD_LOCK       = 8'h60;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_LOCK_SET   = 8'h01;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

    typedef enum logic [1:0] {MD_ARRAY, MD_ID, MD_STATUS} mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ERASE, ST_WRITE, ST_LOCK, ST_RST, ST_WAKE
    } state_e;

    typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_WRITE, PD_LOCK} pend_e;

    typedef struct packed {
        logic ready;     // bit 7
        logic esusp;     // bit 6
        logic seq_err;   // bit 5
        logic rsv4;
        logic vpp_err;   // bit 3
        logic wsusp;     // bit 2
        logic lock_err;  // bit 1
        logic rsv0;
    } stat_t;

    function automatic logic is_busy(input state_e s);
        return (s == ST_ERASE) || (s == ST_WRITE) || (s == ST_LOCK);
    endfunction

endpackage

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
    parameter int AW     = 6,
    parameter int BLK_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_erase,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    input  logic              lk_set,
    input  logic              lk_clr,
    input  logic [AW-BLK_AW-1:0] lk_blk,
    output logic [(1<<(AW-BLK_AW))-1:0] lock_bits
);
    localparam int DEPTH = 1 << AW;
    localparam int NBLK  = 1 << (AW - BLK_AW);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_erase ? 8'hFF : (mem[wr_addr] & wr_data);
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < NBLK; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst || lk_clr)                             lock_bits[g] <= 1'b0;
            else if (lk_set && lk_blk == (AW-BLK_AW)'(g))  lock_bits[g] <= 1'b1;
        end
    end

    // R10: the engine never alters a block whose lock flag is set
    assert_locked_untouched_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !lock_bits[wr_addr[AW-1:BLK_AW]]);

endmodule

// File: rtl/flash_fe_bus.sv
module flash_fe_bus
    import flash_fe_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h5A,
    parameter logic [7:0] DEV_ID = 8'hC3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       rp_n,
    input  logic       asleep,
    input  mode_e      mode,
    input  stat_t      status,
    input  logic [7:0] rd_data,
    input  logic       lock_bit,
    input  logic [1:0] addr_lo,
    output logic       strobe,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    assign strobe = !we_q && we_n && !ce_n && rp_n && !asleep;
    assign dq_oe  = !ce_n && !oe_n && we_n && rp_n && !asleep;

    always_comb begin
        unique case (mode)
            MD_ID: begin
                case (addr_lo)
                    2'd0:    dq_out = MFR_ID;
                    2'd1:    dq_out = DEV_ID;
                    2'd2:    dq_out = {7'd0, lock_bit};
                    default: dq_out = 8'h00;
                endcase
            end
            MD_STATUS: dq_out = status;
            default:   dq_out = rd_data;
        endcase
    end

endmodule

// File: rtl/flash_fe_cmd.sv
module flash_fe_cmd
    import flash_fe_pkg::*;
#(
    parameter int AW        = 6,
    parameter int BLK_AW    = 4,
    parameter int WRITE_CYC = 6,
    parameter int ERASE_DIV = 4,
    parameter int LOCK_CYC  = 5,
    parameter int RP_MIN    = 8,
    parameter int WAKE_CYC  = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rp_n,
    input  logic        vpp_low,
    input  logic        strobe,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]  cmd_data,
    input  logic [(1<<(AW-BLK_AW))-1:0] lock_bits,
    output mode_e       mode,
    output stat_t       status,
    output logic        asleep,
    output logic        ry_by_n,
    output logic        wr_en,
    output logic        wr_erase,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        lk_set,
    output logic        lk_clr,
    output logic [AW-BLK_AW-1:0] lk_blk
);
    localparam int NB_W = AW - BLK_AW;
    localparam int DV_W = $clog2(ERASE_DIV + 1);
    localparam int WC_W = $clog2(WRITE_CYC + 1);
    localparam int LC_W = $clog2(LOCK_CYC + 1);
    localparam int PD_W = $clog2(RP_MIN + 1);
    localparam int WK_W = $clog2(WAKE_CYC + 1);

    state_e          state;
    pend_e           pend;
    logic            esusp, wsusp, seq_err, vpp_err, lock_err, abort_flag;
    logic [NB_W-1:0] e_blk;
    logic [BLK_AW-1:0] e_idx;
    logic [DV_W-1:0] e_div;
    logic [AW-1:0]   w_addr;
    logic [7:0]      w_data;
    logic [WC_W-1:0] w_cnt;
    logic [LC_W-1:0] l_cnt;
    logic            l_set;
    logic [PD_W-1:0] pd_cnt;
    logic [WK_W-1:0] wk_cnt;

    logic            sus_cmd, tgt_locked, erase_step;
    logic [NB_W-1:0] cmd_blk;

    assign cmd_blk    = cmd_addr[AW-1:BLK_AW];
    assign tgt_locked = lock_bits[cmd_blk];
    assign sus_cmd    = strobe && (cmd_data == CMD_SUSPEND);
    assign erase_step = (e_div == DV_W'(ERASE_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !rp_n) begin
            if (rst || state != ST_RST) pd_cnt <= '0;
            else if (pd_cnt < PD_W'(RP_MIN)) pd_cnt <= pd_cnt + 1'b1;
            state      <= rst ? ST_IDLE : ST_RST;
            abort_flag <= !rst && (abort_flag || is_busy(state));
            mode       <= MD_ARRAY;
            pend       <= PD_NONE;
            {esusp, wsusp, seq_err, vpp_err, lock_err} <= '0;
            e_blk <= '0; e_idx <= '0; e_div <= '0;
            w_addr <= '0; w_data <= '0; w_cnt <= '0;
            l_cnt <= '0; l_set <= 1'b0; wk_cnt <= '0;
        end else begin
            unique case (state)
                ST_RST: begin
                    if (pd_cnt >= PD_W'(RP_MIN)) begin
                        state  <= ST_WAKE;
                        wk_cnt <= '0;
                    end else pd_cnt <= pd_cnt + 1'b1;
                end
                ST_WAKE: begin
                    if (wk_cnt == WK_W'(WAKE_CYC - 1)) begin
                        state      <= ST_IDLE;
                        abort_flag <= 1'b0;
                    end else wk_cnt <= wk_cnt + 1'b1;
                end
                ST_ERASE: begin
                    if (erase_step) begin
                        e_div <= '0;
                        if (&e_idx) begin
                            state <= ST_IDLE;
                            e_idx <= '0;
                        end else begin
                            e_idx <= e_idx + 1'b1;
                            if (sus_cmd) begin state <= ST_IDLE; esusp <= 1'b1; end
                        end
                    end else begin
                        e_div <= e_div + 1'b1;
                        if (sus_cmd) begin state <= ST_IDLE; esusp <= 1'b1; end
                    end
                end
                ST_WRITE: begin
                    if (w_cnt == '0) state <= ST_IDLE;
                    else begin
                        w_cnt <= w_cnt - 1'b1;
                        if (sus_cmd && !esusp) begin state <= ST_IDLE; wsusp <= 1'b1; end
                    end
                end
                ST_LOCK: begin
                    if (l_cnt == '0) state <= ST_IDLE;
                    else             l_cnt <= l_cnt - 1'b1;
                end
                default: begin
                    if (strobe && pend != PD_NONE) begin
                        pend <= PD_NONE;
                        mode <= MD_STATUS;
                        unique case (pend)
                            PD_ERASE: begin
                                if (cmd_data != CMD_CONFIRM) seq_err  <= 1'b1;
                                else if (vpp_low)            vpp_err  <= 1'b1;
                                else if (tgt_locked)         lock_err <= 1'b1;
                                else begin
                                    state <= ST_ERASE; e_blk <= cmd_blk;
                                    e_idx <= '0;       e_div <= '0;
                                end
                            end
                            PD_WRITE: begin
                                if (vpp_low)                      vpp_err  <= 1'b1;
                                else if (tgt_locked)              lock_err <= 1'b1;
                                else if (esusp && cmd_blk == e_blk) seq_err <= 1'b1;
                                else begin
                                    state  <= ST_WRITE; w_addr <= cmd_addr;
                                    w_data <= cmd_data; w_cnt  <= WC_W'(WRITE_CYC - 1);
                                end
                            end
                            default: begin
                                if (cmd_data != CMD_LOCK_SET && cmd_data != CMD_CONFIRM)
                                    seq_err <= 1'b1;
                                else if (vpp_low) vpp_err <= 1'b1;
                                else begin
                                    state <= ST_LOCK; l_set <= (cmd_data == CMD_LOCK_SET);
                                    e_blk <= cmd_blk; l_cnt <= LC_W'(LOCK_CYC - 1);
                                end
                            end
                        endcase
                    end else if (strobe) begin
                        case (cmd_data)
                            CMD_READ_ARRAY: mode <= MD_ARRAY;
                            CMD_READ_ID:    mode <= MD_ID;
                            CMD_READ_STAT:  mode <= MD_STATUS;
                            CMD_ERASE, CMD_LOCK: begin
                                if (!esusp && !wsusp) begin
                                    pend <= (cmd_data == CMD_ERASE) ? PD_ERASE : PD_LOCK;
                                    mode <= MD_STATUS;
                                    {seq_err, vpp_err, lock_err} <= '0;
                                end
                            end
                            CMD_WRITE: begin
                                if (!wsusp) begin
                                    pend <= PD_WRITE;
                                    mode <= MD_STATUS;
                                    {seq_err, vpp_err, lock_err} <= '0;
                                end
                            end
                            CMD_CONFIRM: begin
                                if (wsusp) begin
                                    state <= ST_WRITE; wsusp <= 1'b0; mode <= MD_STATUS;
                                end else if (esusp) begin
                                    state <= ST_ERASE; esusp <= 1'b0; mode <= MD_STATUS;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end

    assign asleep   = (state == ST_RST) || (state == ST_WAKE);
    assign ry_by_n  = !is_busy(state) && !abort_flag;
    assign status   = '{ready: !is_busy(state), esusp: esusp, seq_err: seq_err, rsv4: 1'b0,
                        vpp_err: vpp_err, wsusp: wsusp, lock_err: lock_err, rsv0: 1'b0};
    assign wr_erase = (state == ST_ERASE);
    assign wr_en    = rp_n && (((state == ST_ERASE) && erase_step) ||
                               ((state == ST_WRITE) && w_cnt == '0));
    assign wr_addr  = wr_erase ? {e_blk, e_idx} : w_addr;
    assign wr_data  = w_data;
    assign lk_set   = rp_n && (state == ST_LOCK) && l_cnt == '0 && l_set;
    assign lk_clr   = rp_n && (state == ST_LOCK) && l_cnt == '0 && !l_set;
    assign lk_blk   = e_blk;

    // R1: the last wake cycle lands in array mode with a clean status byte
    assert_wake_to_array_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && rp_n && wk_cnt == WK_W'(WAKE_CYC - 1))
        |=> (state == ST_IDLE && mode == MD_ARRAY && status == 8'h80));

    // R8: pulling rp_n during an operation aborts it and holds busy low
    assert_abort_holds_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (is_busy(state) && !rp_n) |=> (!ry_by_n && state == ST_RST));

    // R9: a confirm cycle under programming-voltage lockout starts nothing
    assert_vpp_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && strobe && pend != PD_NONE && vpp_low) |=> state == ST_IDLE);

    // R6: without bus activity a byte write keeps counting down
    assert_write_runs_on_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && w_cnt != '0 && rp_n && !strobe)
        |=> (state == ST_WRITE && w_cnt == $past(w_cnt) - 1'b1));

    // R7: sleep lasts at least RP_MIN cycles
    assert_rp_min_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RST && pd_cnt < PD_W'(RP_MIN)) |=> state == ST_RST);

endmodule

// File: rtl/flash_ctl_front.sv
module flash_ctl_front
    import flash_fe_pkg::*;
#(
    parameter int         AW        = 6,
    parameter int         BLK_AW    = 4,
    parameter int         WRITE_CYC = 6,
    parameter int         ERASE_DIV = 4,
    parameter int         LOCK_CYC  = 5,
    parameter int         RP_MIN    = 8,
    parameter int         WAKE_CYC  = 5,
    parameter logic [7:0] MFR_ID    = 8'h5A,
    parameter logic [7:0] DEV_ID    = 8'hC3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          rp_n,
    input  logic          vpp_low,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    dq_in,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    output logic          ry_by_n
);
    localparam int NB_W = AW - BLK_AW;
    localparam int NBLK = 1 << NB_W;

    mode_e           mode;
    stat_t           status;
    logic            asleep, strobe, wr_en, wr_erase, lk_set, lk_clr;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data, rd_data;
    logic [NB_W-1:0] lk_blk;
    logic [NBLK-1:0] lock_bits;

    flash_fe_bus #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .asleep(asleep), .mode(mode), .status(status), .rd_data(rd_data),
        .lock_bit(lock_bits[addr[AW-1:BLK_AW]]), .addr_lo(addr[1:0]),
        .strobe(strobe), .dq_out(dq_out), .dq_oe(dq_oe));

    flash_fe_cmd #(
        .AW(AW), .BLK_AW(BLK_AW), .WRITE_CYC(WRITE_CYC), .ERASE_DIV(ERASE_DIV),
        .LOCK_CYC(LOCK_CYC), .RP_MIN(RP_MIN), .WAKE_CYC(WAKE_CYC)
    ) u_cmd (
        .clk(clk), .rst(rst), .rp_n(rp_n), .vpp_low(vpp_low), .strobe(strobe),
        .cmd_addr(addr), .cmd_data(dq_in), .lock_bits(lock_bits), .mode(mode),
        .status(status), .asleep(asleep), .ry_by_n(ry_by_n), .wr_en(wr_en),
        .wr_erase(wr_erase), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_set(lk_set), .lk_clr(lk_clr), .lk_blk(lk_blk));

    flash_fe_array #(.AW(AW), .BLK_AW(BLK_AW)) u_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_erase(wr_erase), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data), .lk_set(lk_set),
        .lk_clr(lk_clr), .lk_blk(lk_blk), .lock_bits(lock_bits));

endmodule

// File: tb/tb_flash_ctl_front.sv
module tb_flash_ctl_front;
    localparam int AW = 6, BLK_AW = 4, WRITE_CYC = 6, ERASE_DIV = 4;
    localparam int LOCK_CYC = 5, RP_MIN = 8, WAKE_CYC = 5;
    localparam logic [7:0] MFR = 8'h5A, DEV = 8'hC3;

    logic clk = 1'b0, rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, vpp_low = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] dq_in = '0, dq_out;
    logic dq_oe, ry_by_n;

    int checks = 0, errors = 0;
    logic [7:0] model [64];

    flash_ctl_front #(.AW(AW), .BLK_AW(BLK_AW), .WRITE_CYC(WRITE_CYC),
        .ERASE_DIV(ERASE_DIV), .LOCK_CYC(LOCK_CYC), .RP_MIN(RP_MIN),
        .WAKE_CYC(WAKE_CYC), .MFR_ID(MFR), .DEV_ID(DEV)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
        .vpp_low(vpp_low), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .ry_by_n(ry_by_n));

    always #10 clk = ~clk;

    function automatic logic [7:0] st(input bit es, input bit sq, input bit vp,
                                      input bit ws, input bit lk);
        return {1'b1, es, sq, 1'b0, vp, ws, lk, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; dq_in = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #2 d = dq_oe ? dq_out : 8'hxx;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ry_by_n && n < 2000) begin @(negedge clk); n++; end
        if (n >= 2000) check("wait_ready", 0, 1);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input string req);
        int n;
        bus_write(a, 8'h40);
        bus_write(a, d);
        check(req, ry_by_n, 1'b0);
        wait_ready(n);
        model[a] = model[a] & d;
    endtask

    initial begin : watchdog
        #3000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        int n, bad;
        logic [AW-1:0] a;
        n = $urandom(32'd4711);
        for (int i = 0; i < 64; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        @(negedge clk); #2;
        check("R3 ce high after reset", dq_oe, 1'b0);
        check("R1 ready after reset", ry_by_n, 1'b1);
        bus_read(0, v);  check("R1 array after reset", v, 8'hFF);
        bus_write(0, 8'h70);
        bus_read(0, v);  check("R2 status after reset", v, 8'h80);

        // identification
        bus_write(0, 8'h90);
        bus_read(0, v);  check("R2 mfr id", v, MFR);
        bus_read(1, v);  check("R2 dev id", v, DEV);
        bus_read(2, v);  check("R2 lock flag unlocked", v, 8'h00);
        bus_write(0, 8'hFF);

        // random byte writes
        for (int k = 0; k < 24; k++) begin
            a = AW'($urandom_range(0, 63));
            v = 8'($urandom);
            do_write(a, v, "R4 busy during write");
            bus_read(a, v);  check("R4 status after write", v, 8'h80);
            bus_write(a, 8'hFF);
            bus_read(a, v);  check("R4 readback", v, model[a]);
        end

        // deselect does not stop a write
        bus_write(9, 8'h40); bus_write(9, 8'hA5);
        repeat (2) @(negedge clk);
        check("R6 busy while deselected", ry_by_n, 1'b0);
        wait_ready(n); model[9] = model[9] & 8'hA5;
        bus_write(0, 8'hFF);
        bus_read(9, v);  check("R6 write completed deselected", v, model[9]);

        // output disable conditions
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #2;
        check("R3 oe high", dq_oe, 1'b0);
        ce_n = 1'b1; oe_n = 1'b0; #2;
        check("R3 ce high", dq_oe, 1'b0);
        ce_n = 1'b0; we_n = 1'b0; #2;
        check("R3 we low", dq_oe, 1'b0);
        we_n = 1'b1; #2;
        check("R3 driven", dq_oe, 1'b1);
        ce_n = 1'b1; oe_n = 1'b1;

        // block erase of block 1
        bus_write(20, 8'h20); bus_write(20, 8'hD0);
        check("R5 busy during erase", ry_by_n, 1'b0);
        wait_ready(n);
        bus_read(0, v);  check("R5 status after erase", v, 8'h80);
        bus_write(0, 8'hFF);
        bad = 0;
        for (int i = 16; i < 32; i++) begin
            bus_read(AW'(i), v); if (v !== 8'hFF) bad++; model[i] = 8'hFF;
        end
        check("R5 block all FF", bad, 0);
        bus_read(0, v);  check("R5 other block kept", v, model[0]);

        // bad confirm, then error clearing
        bus_write(0, 8'h20); bus_write(0, 8'h55);
        bus_read(0, v);  check("R5 bad confirm status", v, st(0, 1, 0, 0, 0));
        do_write(0, 8'hFF, "R4 busy");
        bus_read(0, v);  check("R13 errors cleared", v, 8'h80);

        // programming-voltage lockout
        vpp_low = 1'b1;
        bus_write(3, 8'h40); bus_write(3, 8'h00);
        #2 check("R9 no busy under lockout", ry_by_n, 1'b1);
        bus_read(3, v);  check("R9 vpp error bit", v, st(0, 0, 1, 0, 0));
        vpp_low = 1'b0;
        bus_write(0, 8'hFF);
        bus_read(3, v);  check("R9 data unchanged", v, model[3]);

        // lock flags
        bus_write(32, 8'h60); bus_write(32, 8'h01); wait_ready(n);
        bus_write(0, 8'h90);
        bus_read(34, v); check("R10 lock flag set", v, 8'h01);
        bus_read(2, v);  check("R10 other block unlocked", v, 8'h00);
        bus_write(33, 8'h40); bus_write(33, 8'h00);
        bus_read(33, v); check("R10 locked write refused", v, st(0, 0, 0, 0, 1));
        bus_write(0, 8'hFF);
        bus_read(33, v); check("R10 locked data kept", v, model[33]);
        bus_write(32, 8'h60); bus_write(32, 8'hD0); wait_ready(n);
        bus_write(0, 8'h90);
        bus_read(34, v); check("R10 lock flags cleared", v, 8'h00);

        // erase suspend with a nested write
        bus_write(48, 8'h20); bus_write(48, 8'hD0);
        repeat (6) @(negedge clk);
        bus_write(48, 8'hB0); wait_ready(n);
        bus_read(0, v);  check("R11 erase paused status", v, st(1, 0, 0, 0, 0));
        do_write(5, 8'h0F, "R11 nested write busy");
        bus_read(0, v);  check("R11 still paused", v, st(1, 0, 0, 0, 0));
        bus_write(0, 8'hFF);
        bus_read(5, v);  check("R11 nested write data", v, model[5]);
        bus_write(48, 8'hD0);
        check("R11 resumed busy", ry_by_n, 1'b0);
        wait_ready(n);
        bus_read(0, v);  check("R11 resumed done", v, 8'h80);
        bus_write(0, 8'hFF);
        bad = 0;
        for (int i = 48; i < 64; i++) begin
            bus_read(AW'(i), v); if (v !== 8'hFF) bad++; model[i] = 8'hFF;
        end
        check("R11 suspended block erased", bad, 0);

        // write suspend
        bus_write(7, 8'h40); bus_write(7, 8'h3C);
        bus_write(7, 8'hB0); wait_ready(n);
        bus_read(0, v);  check("R12 write paused status", v, st(0, 0, 0, 1, 0));
        bus_write(0, 8'hFF);
        bus_read(7, v);  check("R12 byte not yet altered", v, model[7]);
        bus_write(7, 8'hD0); wait_ready(n);
        model[7] = model[7] & 8'h3C;
        bus_read(0, v);  check("R12 resumed status", v, 8'h80);
        bus_write(0, 8'hFF);
        bus_read(7, v);  check("R12 resumed data", v, model[7]);

        // abort in the middle of an erase
        do_write(16, 8'h12, "R4 busy");
        do_write(31, 8'h34, "R4 busy");
        bus_write(16, 8'h20); bus_write(16, 8'hD0);
        repeat (9) @(negedge clk);
        rp_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; #2;
        check("R8 busy after abort", ry_by_n, 1'b0);
        check("R7 outputs off asleep", dq_oe, 1'b0);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (RP_MIN + 1) @(negedge clk);
        rp_n = 1'b1;
        @(negedge clk);
        check("R8 busy through wake", ry_by_n, 1'b0);
        wait_ready(n);
        check("R7 wake length", n + 1, WAKE_CYC + 1);
        bus_read(16, v); check("R8 erased byte stays erased", v, 8'hFF);
        bus_read(31, v); check("R1 array mode after wake", v, 8'h34);
        model[16] = 8'hFF; model[17] = 8'hFF;
        bus_write(0, 8'h70);
        bus_read(0, v);  check("R1 status 80 after wake", v, 8'h80);
        bus_write(0, 8'hFF);

        // short rp pulse still gives a full sleep
        @(negedge clk); rp_n = 1'b0;
        @(negedge clk); rp_n = 1'b1;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; #2;
        check("R7 short pulse still asleep", dq_oe, 1'b0);
        check("R7 no abort idle", ry_by_n, 1'b1);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (RP_MIN + WAKE_CYC + 4) @(negedge clk);
        bus_read(0, v);  check("R7 awake again", v, model[0]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule